// File: doc/BRIEF.md
# Multiplexed-Bus Memory and Port Front End

This block connects a host CPU that shares eight wires between address and data to a small peripheral. The peripheral holds a 256-byte scratch RAM and a register space. While the address strobe `ale` is high, the block follows the bus value, the chip-select pin and the space-select pin. When the strobe falls, it freezes all three. The read strobe and the write strobe that come after act on these frozen values and not on the live pins.

The register space holds a four-bit configuration register (written at offset 0), a status view of that register (read at offset 0), and the latches for three general ports A, B and C. Each port can be set to input or output. When a port is an input, a read returns its pins. When it is an output, a read returns its latch and the pins are driven from that latch. The bus is modelled with a separate input, output and output enable, and the enable is raised only during a qualified read. The polarity of the chip select is chosen when the block is built.

Top module: `mbus_periph`

## Requirements
- R1: While `ale` is high on a clock edge, the `ad_i` value is taken as the access address. After `ale` goes low, changes on `ad_i` do not alter which location a read or a write targets.
- R2: The chip-select level and the space-select level (`iom`) are frozen together with the address. Toggling either pin after `ale` falls does not change how the access is qualified or which space it targets.
- R3: `ad_oe` is high exactly when `rd_n` is low and the frozen chip select is active. In every other cycle the bus is released.
- R4: With `iom` latched at 0, a write stores `ad_i` into RAM byte `addr`, and a later read of `addr` returns that byte. All 256 addresses can be reached.
- R5: With `iom` latched at 1, a write to offset 0 loads bits 3:0 of the data into the configuration register. A read of offset 0 returns `{4'b0, config[3:0]}`.
- R6: Configuration bit 0 set to 1 makes port A an output: `pa_oe` is all ones and `pa_o` carries the offset-1 latch. With the bit at 0, `pa_oe` is zero and a read of offset 1 returns `pa_i`. The latch can be written in either direction.
- R7: Configuration bit 1 and offset 2 control port B in the same way.
- R8: Configuration bits 3:2 choose the port C mode. 0 makes all six bits inputs. 1 makes bits 2:0 outputs. 2 makes bits 5:3 outputs. 3 makes all six bits outputs. A read of offset 3 returns the latch for output bits and the pins for input bits, with bits 7:6 read as zero.
- R9: Register offsets 4 to 255 read as zero. Writes to them change no register or port.
- R10: An access whose frozen chip select is inactive writes nothing and does not drive the bus. With the default build the select is active low.
- R11: While `rst` is high, the configuration register and all port latches clear, so all three ports become inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; the block follows the bus while it is high |
| ce_pin | input | 1 | Chip select; polarity set by `CE_ACTIVE_HIGH` |
| iom | input | 1 | Space select: 0 for RAM, 1 for registers and ports |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Multiplexed address/data bus, input side |
| ad_o | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Bus drive enable |
| pa_i | input | 8 | Port A pins, input side |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit drive enable |
| pb_i | input | 8 | Port B pins, input side |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit drive enable |
| pc_i | input | 6 | Port C pins, input side |
| pc_o | output | 6 | Port C output latch |
| pc_oe | output | 6 | Port C per-bit drive enable |

## Verification
Some properties are checked on every cycle. The bus enable is raised only while a read strobe meets an active frozen select. The frozen address, select and space bits stay stable whenever `ale` is low. Port A and B enables are always all-or-none. Port C enables always form one of the four legal split patterns. Every port is an input in the first cycle after reset. An inactive select leaves the configuration untouched.

Other behaviours only the bench scenarios can show. These are the RAM contents at both ends of the address range, the exact status and port read values across the direction modes, and offsets above 3 being ignored. Pins toggled after `ale` falls must not retarget the access, and this too is shown only by the scenarios.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  typedef enum logic [1:0] {
    PCM_IN     = 2'd0,
    PCM_LO_OUT = 2'd1,
    PCM_HI_OUT = 2'd2,
    PCM_OUT    = 2'd3
  } pc_mode_e;

  localparam int REG_CFG = 0;
  localparam int REG_PA  = 1;
  localparam int REG_PB  = 2;
  localparam int REG_PC  = 3;

  localparam int CFG_W       = 4;
  localparam int CFG_PA_BIT  = 0;
  localparam int CFG_PB_BIT  = 1;
  localparam int CFG_PCM_LSB = 2;

  function automatic logic ce_is_active(logic lvl, bit active_high);
    return active_high ? lvl : ~lvl;
  endfunction

  function automatic logic pc_bit_out(pc_mode_e m, bit upper);
    case (m)
      PCM_OUT:    return 1'b1;
      PCM_LO_OUT: return ~upper;
      PCM_HI_OUT: return upper;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mbp_addr_latch.sv
module mbp_addr_latch #(
  parameter int  DATA_W         = 8,
  parameter bit  CE_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              ce_pin,
  input  logic              iom,
  output logic [DATA_W-1:0] addr_q,
  output logic              ce_q,
  output logic              iom_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ce_q   <= ~CE_ACTIVE_HIGH;
      iom_q  <= 1'b0;
    end else if (ale) begin
      addr_q <= ad_i;
      ce_q   <= ce_pin;
      iom_q  <= iom;
    end
  end

endmodule

// File: rtl/mbp_ram.sv
module mbp_ram #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/mbp_port_regs.sv
module mbp_port_regs
  import mbp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pa_i,
  input  logic [DATA_W-1:0] pb_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pa_oe,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   pc_oe,
  output logic [CFG_W-1:0]  cfg_q
);

  localparam logic [DATA_W-1:0] OFS_CFG = DATA_W'(REG_CFG);
  localparam logic [DATA_W-1:0] OFS_PA  = DATA_W'(REG_PA);
  localparam logic [DATA_W-1:0] OFS_PB  = DATA_W'(REG_PB);
  localparam logic [DATA_W-1:0] OFS_PC  = DATA_W'(REG_PC);
  localparam int                PC_LO   = PC_W / 2;

  logic [DATA_W-1:0] pa_q, pb_q;
  logic [PC_W-1:0]   pc_q;
  pc_mode_e          pc_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      pa_q  <= '0;
      pb_q  <= '0;
      pc_q  <= '0;
    end else if (we) begin
      case (ofs)
        OFS_CFG: cfg_q <= wdata[CFG_W-1:0];
        OFS_PA:  pa_q  <= wdata;
        OFS_PB:  pb_q  <= wdata;
        OFS_PC:  pc_q  <= wdata[PC_W-1:0];
        default: ;
      endcase
    end
  end

  assign pc_mode = pc_mode_e'(cfg_q[CFG_PCM_LSB +: 2]);
  assign pa_oe   = {DATA_W{cfg_q[CFG_PA_BIT]}};
  assign pb_oe   = {DATA_W{cfg_q[CFG_PB_BIT]}};
  assign pa_o    = pa_q;
  assign pb_o    = pb_q;
  assign pc_o    = pc_q;

  // Port C splits into a lower and an upper group that the mode enables separately.
  for (genvar i = 0; i < PC_W; i++) begin : g_pc_dir
    assign pc_oe[i] = pc_bit_out(pc_mode, i >= PC_LO);
  end

  always_comb begin
    case (ofs)
      OFS_CFG: rdata = DATA_W'(cfg_q);
      OFS_PA:  rdata = (pa_q & pa_oe) | (pa_i & ~pa_oe);
      OFS_PB:  rdata = (pb_q & pb_oe) | (pb_i & ~pb_oe);
      OFS_PC:  rdata = DATA_W'((pc_q & pc_oe) | (pc_i & ~pc_oe));
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbus_periph.sv
module mbus_periph
  import mbp_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int PC_W           = 6,
  parameter bit CE_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              ce_pin,
  input  logic              iom,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] pa_i,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_i,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [PC_W-1:0]   pc_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   pc_oe
);

  logic [DATA_W-1:0] addr_q, ram_rdata, reg_rdata;
  logic              ce_q, iom_q;
  logic              ce_act, rd_act, wr_act, ram_we, reg_we;
  logic [CFG_W-1:0]  cfg_q;

  mbp_addr_latch #(.DATA_W(DATA_W), .CE_ACTIVE_HIGH(CE_ACTIVE_HIGH)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_i(ad_i), .ce_pin(ce_pin), .iom(iom),
    .addr_q(addr_q), .ce_q(ce_q), .iom_q(iom_q)
  );

  assign ce_act = ce_is_active(ce_q, CE_ACTIVE_HIGH);
  assign rd_act = ~rd_n & ce_act;
  assign wr_act = ~wr_n & ce_act;
  assign ram_we = wr_act & ~iom_q;
  assign reg_we = wr_act & iom_q;

  mbp_ram #(.DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(addr_q), .wdata(ad_i), .rdata(ram_rdata)
  );

  mbp_port_regs #(.DATA_W(DATA_W), .PC_W(PC_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .ofs(addr_q), .wdata(ad_i),
    .pa_i(pa_i), .pb_i(pb_i), .pc_i(pc_i), .rdata(reg_rdata),
    .pa_o(pa_o), .pa_oe(pa_oe), .pb_o(pb_o), .pb_oe(pb_oe),
    .pc_o(pc_o), .pc_oe(pc_oe), .cfg_q(cfg_q)
  );

  assign ad_oe = rd_act;
  assign ad_o  = iom_q ? reg_rdata : ram_rdata;

endmodule

// File: rtl/mbus_periph_chk.sv
module mbus_periph_chk #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 6,
  parameter int CFG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              rd_n,
  input logic              ad_oe,
  input logic              ce_act,
  input logic [DATA_W-1:0] addr_q,
  input logic              ce_q,
  input logic              iom_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic [DATA_W-1:0] pa_oe,
  input logic [DATA_W-1:0] pb_oe,
  input logic [PC_W-1:0]   pc_oe
);

  localparam int LO_N = PC_W / 2;
  localparam int HI_N = PC_W - LO_N;

  AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (!rd_n && ce_act)); // R3
  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && ce_act) |-> ad_oe); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr_q)); // R1
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !ale |=> ($stable(ce_q) && $stable(iom_q))); // R2
  AST_INACTIVE_NO_CFG: assert property (@(posedge clk) disable iff (rst)
    !ce_act |=> $stable(cfg_q)); // R10
  AST_PA_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
    ($countones(pa_oe) == 0) || ($countones(pa_oe) == DATA_W)); // R6
  AST_PB_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
    ($countones(pb_oe) == 0) || ($countones(pb_oe) == DATA_W)); // R7
  AST_PC_SPLIT: assert property (@(posedge clk) disable iff (rst)
    ($countones(pc_oe) == 0) || ($countones(pc_oe) == LO_N) ||
    ($countones(pc_oe) == HI_N) || ($countones(pc_oe) == PC_W)); // R8
  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0)); // R11

endmodule

bind mbus_periph mbus_periph_chk #(.DATA_W(DATA_W), .PC_W(PC_W), .CFG_W(mbp_pkg::CFG_W)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .ad_oe(ad_oe), .ce_act(ce_act),
  .addr_q(addr_q), .ce_q(ce_q), .iom_q(iom_q), .cfg_q(cfg_q),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/sim_mbus_periph.sv
`timescale 1ns/1ps
module sim_mbus_periph;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0, ce_pin = 1'b1, iom = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_i = 8'h00, pa_i = 8'h00, pb_i = 8'h00;
  logic [5:0] pc_i = 6'h00;
  logic [7:0] ad_o, pa_o, pa_oe, pb_o, pb_oe;
  logic       ad_oe;
  logic [5:0] pc_o, pc_oe;

  always #2.5 clk = ~clk;

  mbus_periph u0 (
    .clk(clk), .rst(rst), .ale(ale), .ce_pin(ce_pin), .iom(iom),
    .rd_n(rd_n), .wr_n(wr_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe), .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R11";

  // Behavioural reference state
  int m_ram [int];
  int m_cfg = 0, m_pa = 0, m_pb = 0, m_pc = 0;
  int m_addr = 0, m_ce = 1, m_iom = 0;

  function automatic int pc_mask(int cfg);
    case ((cfg >> 2) & 3)
      1: return 'h07;
      2: return 'h38;
      3: return 'h3F;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_pa = 0; m_pb = 0; m_pc = 0;
      m_addr = 0; m_ce = 1; m_iom = 0;
    end else begin
      if (!wr_n && m_ce == 0) begin
        if (m_iom == 0) m_ram[m_addr] = int'(ad_i);
        else if (m_addr == 0) m_cfg = int'(ad_i) & 'hF;
        else if (m_addr == 1) m_pa = int'(ad_i);
        else if (m_addr == 2) m_pb = int'(ad_i);
        else if (m_addr == 3) m_pc = int'(ad_i) & 'h3F;
      end
      if (ale) begin m_addr = int'(ad_i); m_ce = int'(ce_pin); m_iom = int'(iom); end
    end
  end

  function automatic int exp_read(output bit known);
    int pam, pbm, pcm;
    known = 1;
    pam = (m_cfg & 1) ? 'hFF : 0;
    pbm = (m_cfg & 2) ? 'hFF : 0;
    pcm = pc_mask(m_cfg);
    if (m_iom == 0) begin
      if (m_ram.exists(m_addr)) return m_ram[m_addr];
      known = 0; return 0;
    end
    case (m_addr)
      0: return m_cfg;
      1: return (m_pa & pam) | (int'(pa_i) & ~pam & 'hFF);
      2: return (m_pb & pbm) | (int'(pb_i) & ~pbm & 'hFF);
      3: return (m_pc & pcm) | (int'(pc_i) & ~pcm & 'h3F);
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit known;
    int ev;
    int e_oe;
    e_oe = (!rd_n && m_ce == 0) ? 1 : 0;
    chk(int'(ad_oe) == e_oe, cur_tag, "ad_oe", int'(ad_oe), e_oe);
    ev = exp_read(known);
    if (e_oe == 1 && known) chk(int'(ad_o) == ev, cur_tag, "ad_o", int'(ad_o), ev);
    chk(int'(pa_oe) == ((m_cfg & 1) ? 'hFF : 0), cur_tag, "pa_oe", int'(pa_oe), (m_cfg & 1) ? 'hFF : 0);
    chk(int'(pb_oe) == ((m_cfg & 2) ? 'hFF : 0), cur_tag, "pb_oe", int'(pb_oe), (m_cfg & 2) ? 'hFF : 0);
    chk(int'(pc_oe) == pc_mask(m_cfg), cur_tag, "pc_oe", int'(pc_oe), pc_mask(m_cfg));
    chk(int'(pa_o) == m_pa && int'(pb_o) == m_pb && int'(pc_o) == m_pc, cur_tag, "port latches",
        int'({pa_o, pb_o, 2'b0, pc_o}), (m_pa << 16) | (m_pb << 8) | m_pc);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic bus_addr(bit sp, logic [7:0] a, bit ce_on);
    ale = 1; ad_i = a; ce_pin = ce_on ? 1'b0 : 1'b1; iom = sp;
    step();
    ale = 0;
    step();
  endtask

  task automatic bus_wr(bit sp, logic [7:0] a, logic [7:0] d, bit ce_on);
    bus_addr(sp, a, ce_on);
    ad_i = d; wr_n = 0;
    step();
    wr_n = 1; ce_pin = 1;
    step();
  endtask

  task automatic bus_rd(bit sp, logic [7:0] a, bit ce_on, bit flip, bit e_oe, int e, string tag);
    bus_addr(sp, a, ce_on);
    if (flip) begin iom = ~iom; ce_pin = ~ce_pin; end
    ad_i = 8'hC3; rd_n = 0;
    step();
    chk(ad_oe == e_oe, tag, "read enable", int'(ad_oe), int'(e_oe));
    if (e_oe) chk(int'(ad_o) == e, tag, "read data", int'(ad_o), e);
    rd_n = 1; ce_pin = 1;
    step();
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset leaves all ports as inputs and the config cleared
    cur_tag = "R11";
    step();
    chk(pa_oe == 0 && pb_oe == 0 && pc_oe == 0, "R11", "oe after reset", int'({pa_oe, pb_oe}), 0);
    bus_rd(1, 8'h00, 1, 0, 1, 0, "R11");

    // R4: RAM at both ends and middle
    cur_tag = "R4";
    bus_wr(0, 8'h00, 8'h11, 1);
    bus_wr(0, 8'hFF, 8'hEE, 1);
    bus_wr(0, 8'h5A, 8'h7C, 1);
    bus_rd(0, 8'h00, 1, 0, 1, 'h11, "R4");
    bus_rd(0, 8'hFF, 1, 0, 1, 'hEE, "R4");
    bus_rd(0, 8'h5A, 1, 0, 1, 'h7C, "R4");
    chk(pa_oe == 0 && pa_o == 0, "R4", "RAM write leaves ports", int'(pa_o), 0);

    // R1: bus value after ale falls is ignored for targeting (bus_rd drives C3)
    cur_tag = "R1";
    bus_rd(0, 8'hFF, 1, 0, 1, 'hEE, "R1");

    // R5: config write and status read
    cur_tag = "R5";
    bus_wr(1, 8'h00, 8'hF0, 1);
    bus_rd(1, 8'h00, 1, 0, 1, 'h00, "R5");
    bus_wr(1, 8'h00, 8'hF3, 1);
    bus_rd(1, 8'h00, 1, 0, 1, 'h03, "R5");

    // R2: flip iom and ce after latching; access stays in register space and qualified
    cur_tag = "R2";
    bus_rd(1, 8'h00, 1, 1, 1, 'h03, "R2");

    // R6: port A input then output
    cur_tag = "R6";
    bus_wr(1, 8'h00, 8'h00, 1);
    pa_i = 8'h3C;
    bus_wr(1, 8'h01, 8'hA5, 1);
    chk(pa_oe == 8'h00, "R6", "pa input mode", int'(pa_oe), 0);
    bus_rd(1, 8'h01, 1, 0, 1, 'h3C, "R6");
    bus_wr(1, 8'h00, 8'h01, 1);
    chk(pa_oe == 8'hFF && pa_o == 8'hA5, "R6", "pa output mode", int'({pa_oe, pa_o}), 'hFFA5);
    bus_rd(1, 8'h01, 1, 0, 1, 'hA5, "R6");

    // R7: port B
    cur_tag = "R7";
    pb_i = 8'h96;
    bus_wr(1, 8'h02, 8'h4B, 1);
    bus_rd(1, 8'h02, 1, 0, 1, 'h96, "R7");
    bus_wr(1, 8'h00, 8'h02, 1);
    chk(pb_oe == 8'hFF && pb_o == 8'h4B, "R7", "pb output mode", int'({pb_oe, pb_o}), 'hFF4B);
    bus_rd(1, 8'h02, 1, 0, 1, 'h4B, "R7");

    // R8: port C in all four modes
    cur_tag = "R8";
    pc_i = 6'h2A;
    bus_wr(1, 8'h03, 8'hD5, 1);
    bus_wr(1, 8'h00, 8'h00, 1);
    bus_rd(1, 8'h03, 1, 0, 1, 'h2A, "R8");
    bus_wr(1, 8'h00, 8'h04, 1);
    chk(pc_oe == 6'h07, "R8", "pc mode 1 enable", int'(pc_oe), 'h07);
    bus_rd(1, 8'h03, 1, 0, 1, 'h2D, "R8");
    bus_wr(1, 8'h00, 8'h08, 1);
    chk(pc_oe == 6'h38, "R8", "pc mode 2 enable", int'(pc_oe), 'h38);
    bus_rd(1, 8'h03, 1, 0, 1, 'h12, "R8");
    bus_wr(1, 8'h00, 8'h0C, 1);
    bus_rd(1, 8'h03, 1, 0, 1, 'h15, "R8");

    // R9: unused offsets
    cur_tag = "R9";
    bus_wr(1, 8'h04, 8'hFF, 1);
    bus_wr(1, 8'hFF, 8'h00, 1);
    bus_rd(1, 8'h04, 1, 0, 1, 0, "R9");
    bus_rd(1, 8'hFF, 1, 0, 1, 0, "R9");
    bus_rd(1, 8'h00, 1, 0, 1, 'h0C, "R9");
    chk(pc_o == 6'h15 && pa_o == 8'hA5, "R9", "ports untouched", int'({pa_o, 2'b0, pc_o}), 'hA515);

    // R10 / R3: inactive select
    cur_tag = "R10";
    bus_wr(0, 8'h5A, 8'h00, 0);
    bus_wr(1, 8'h00, 8'h00, 0);
    bus_rd(0, 8'h5A, 0, 0, 0, 0, "R10");
    bus_rd(0, 8'h5A, 1, 0, 1, 'h7C, "R10");
    bus_rd(1, 8'h00, 1, 0, 1, 'h0C, "R10");
    cur_tag = "R3";
    step();
    chk(ad_oe == 0, "R3", "released when idle", int'(ad_oe), 0);

    // R11: mid-run reset
    cur_tag = "R11";
    rst = 1;
    step();
    rst = 0;
    step();
    chk(pa_oe == 0 && pb_oe == 0 && pc_oe == 0 && pa_o == 0, "R11", "ports after reset",
        int'({pa_oe, pb_oe, 2'b0, pc_oe}), 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule